// File: doc/BRIEF.md
# Stage-2 Fault Address Capture Register

This block is a 64-bit register at hypervisor privilege. It records the intermediate physical address of a stage-2 translation abort that is delivered to the hypervisor. When the abort logic pulses a capture strobe, the block takes the faulting page number, the security space it came from, the implemented physical address width and the stage-2 granule. It then packs them into a fixed layout. Captures from memory-copy or memory-set instructions are aligned down to the current granule. Address bits above the implemented width are forced to zero.

Software reaches the register through system-register move instructions. The access port carries the five encoding fields, a direction bit, the current exception level, a nested-virtualization trap bit and the write data. The block decodes the encoding and applies the privilege rule. Each access at a lower level ends in exactly one outcome: a trap to the hypervisor, an undefined-instruction report, or a plain transfer for the two highest levels. The result is returned one cycle after the request. A separate indication, asserted while a lower level runs, clears the contents, because the register holds no defined value after execution there.

Top module: `s2_fault_addr_reg`

## Requirements
- R1: While reset is asserted and after it, the register holds zero and rd_vld, acc_undef and acc_trap are low; the first read at EL2 returns zero.
- R2: A capture stores cap_nonsec in bit 63 (1 = Non-secure space, 0 = Secure space) and the page number (address bits [55:12]) in bits [47:4]; bits [62:48] and [3:0] are zero.
- R3: cap_pa_sel selects the implemented physical address width: 0 = 48 bits, 1 = 52 bits, 2 or 3 = 56 bits. Captured address bits at or above that width read as zero.
- R4: With cap_mem_op set, address bits from 12 up to the granule shift are zeroed. cap_gran gives the shift: 0 = 4 KB (12), 1 = 16 KB (14), 2 = 64 KB (16), 3 = 4 KB. With cap_mem_op clear, no granule alignment is applied.
- R5: Only the encoding op0=2'b11, op1=3'b100, CRn=4'b0110, CRm=4'b0000, op2=3'b100 is decoded. Any other encoding produces no response and leaves the register unchanged.
- R6: A matching access at EL0 (acc_el=0) reports acc_undef. A write there has no effect.
- R7: A matching access at EL1 (acc_el=1) reports acc_trap with trap_ec=6'h18 when acc_nv_trap is 1, and acc_undef otherwise. A write at EL1 has no effect.
- R8: At EL2 or EL3 (acc_el=2 or 3), a read returns the full register and a write stores acc_wdata with bits [62:48] and [3:0] forced to zero.
- R9: rd_vld, acc_undef and acc_trap are one-cycle pulses in the cycle after the request, at most one at a time. rd_data is zero when rd_vld is low. trap_ec is zero when acc_trap is low. A write that is permitted produces no pulse.
- R10: A capture and a permitted write in the same cycle store the captured value.
- R11: lower_exec clears the register. A capture in the same cycle wins over the clear, and the clear wins over a permitted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cap_vld | input | 1 | Abort capture strobe |
| cap_page | input | 44 | Faulting address bits [55:12] |
| cap_nonsec | input | 1 | Faulting address space, 1 = Non-secure |
| cap_pa_sel | input | 2 | Implemented physical address width select |
| cap_gran | input | 2 | Stage-2 granule select |
| cap_mem_op | input | 1 | Capture came from a memory-copy or memory-set instruction |
| lower_exec | input | 1 | EL1/EL0 execution indication, clears the register |
| acc_vld | input | 1 | System-register access request |
| acc_op0 | input | 2 | Encoding field op0 |
| acc_op1 | input | 3 | Encoding field op1 |
| acc_crn | input | 4 | Encoding field CRn |
| acc_crm | input | 4 | Encoding field CRm |
| acc_op2 | input | 3 | Encoding field op2 |
| acc_wr | input | 1 | 1 = write (move to register), 0 = read |
| acc_el | input | 2 | Current exception level |
| acc_nv_trap | input | 1 | Nested-virtualization trap enable for EL1 accesses |
| acc_wdata | input | 64 | Write data |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| acc_undef | output | 1 | Access is undefined |
| acc_trap | output | 1 | Access traps to EL2 |
| trap_ec | output | 6 | Trap syndrome class |

## Verification
The hardest states to reach are the collisions. These are a capture landing in the same cycle as a permitted write or as the lower-level clear, and a denied write that must leave the contents untouched. None of them shows at the ports until a later read. The stimulus drives the colliding strobes together in a single cycle, then reads the register back at EL2. The scoreboard compares the read against a model that applies the capture, clear and write priority. Address patterns of all ones are captured under each width and granule setting, so every zeroed bit range shows up in the readback.

// File: rtl/s2far_pkg.sv
package s2far_pkg;
  localparam int REG_W    = 64;
  localparam int ADDR_W   = 56;
  localparam int PG_SHIFT = 12;
  localparam int FLD_LO   = 4;
  localparam int NS_BIT   = 63;
  localparam int EC_W     = 6;

  localparam int PA_W_A   = 48;
  localparam int PA_W_B   = 52;
  localparam int PA_W_C   = 56;
  localparam int GR_SH_4K  = 12;
  localparam int GR_SH_16K = 14;
  localparam int GR_SH_64K = 16;

  localparam logic [EC_W-1:0] TRAP_EC_HYP = 6'h18;

  localparam logic [1:0] ENC_OP0 = 2'b11;
  localparam logic [2:0] ENC_OP1 = 3'b100;
  localparam logic [3:0] ENC_CRN = 4'b0110;
  localparam logic [3:0] ENC_CRM = 4'b0000;
  localparam logic [2:0] ENC_OP2 = 3'b100;

  typedef enum logic [1:0] {
    PA_SEL_48  = 2'd0,
    PA_SEL_52  = 2'd1,
    PA_SEL_56  = 2'd2,
    PA_SEL_56X = 2'd3
  } pa_sel_e;

  typedef enum logic [1:0] {
    GR_4K   = 2'd0,
    GR_16K  = 2'd1,
    GR_64K  = 2'd2,
    GR_RSVD = 2'd3
  } gran_e;

  typedef enum logic [1:0] {
    LVL_EL0 = 2'd0,
    LVL_EL1 = 2'd1,
    LVL_EL2 = 2'd2,
    LVL_EL3 = 2'd3
  } lvl_e;

  typedef struct packed {
    logic grant_rd;
    logic grant_wr;
    logic undef;
    logic trap;
  } acc_dec_t;
endpackage

// File: rtl/s2far_access_dec.sv
module s2far_access_dec
  import s2far_pkg::*;
(
  input  logic       acc_vld,
  input  logic [1:0] acc_op0,
  input  logic [2:0] acc_op1,
  input  logic [3:0] acc_crn,
  input  logic [3:0] acc_crm,
  input  logic [2:0] acc_op2,
  input  logic       acc_wr,
  input  logic [1:0] acc_el,
  input  logic       acc_nv_trap,
  output acc_dec_t   dec
);
  logic enc_hit;
  lvl_e lvl;

  assign enc_hit = acc_vld && (acc_op0 == ENC_OP0) && (acc_op1 == ENC_OP1) &&
                   (acc_crn == ENC_CRN) && (acc_crm == ENC_CRM) &&
                   (acc_op2 == ENC_OP2);
  assign lvl = lvl_e'(acc_el);

  always_comb begin
    dec = '0;
    if (enc_hit) begin
      unique case (lvl)
        LVL_EL0: dec.undef = 1'b1;
        LVL_EL1: begin
          if (acc_nv_trap) dec.trap  = 1'b1;
          else             dec.undef = 1'b1;
        end
        default: begin
          dec.grant_rd = !acc_wr;
          dec.grant_wr = acc_wr;
        end
      endcase
    end
  end
endmodule

// File: rtl/s2far_capture_fmt.sv
module s2far_capture_fmt
  import s2far_pkg::*;
#(
  parameter int P_REG_W  = REG_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_PG_SH  = PG_SHIFT,
  parameter int P_FLD_LO = FLD_LO,
  parameter int P_NS_BIT = NS_BIT
) (
  input  logic [P_ADDR_W-P_PG_SH-1:0] cap_page,
  input  logic                        cap_nonsec,
  input  logic [1:0]                  cap_pa_sel,
  input  logic [1:0]                  cap_gran,
  input  logic                        cap_mem_op,
  output logic [P_REG_W-1:0]          cap_val
);
  localparam int PG_W  = P_ADDR_W - P_PG_SH;
  localparam int CNT_W = $clog2(P_ADDR_W + 1);
  localparam int FLD_HI = P_FLD_LO + PG_W - 1;

  logic [CNT_W-1:0] pa_lim;
  logic [CNT_W-1:0] gr_lim;
  logic [PG_W-1:0]  keep;
  logic [PG_W-1:0]  page_m;

  always_comb begin
    unique case (pa_sel_e'(cap_pa_sel))
      PA_SEL_48: pa_lim = CNT_W'(PA_W_A);
      PA_SEL_52: pa_lim = CNT_W'(PA_W_B);
      default:   pa_lim = CNT_W'(PA_W_C);
    endcase
    unique case (gran_e'(cap_gran))
      GR_16K:  gr_lim = CNT_W'(GR_SH_16K);
      GR_64K:  gr_lim = CNT_W'(GR_SH_64K);
      default: gr_lim = CNT_W'(GR_SH_4K);
    endcase
  end

  for (genvar g = 0; g < PG_W; g++) begin : g_keep
    localparam logic [CNT_W-1:0] ABIT = CNT_W'(g + P_PG_SH);
    assign keep[g] = (ABIT < pa_lim) && !(cap_mem_op && (ABIT < gr_lim));
  end

  assign page_m = cap_page & keep;

  always_comb begin
    cap_val                    = '0;
    cap_val[P_NS_BIT]          = cap_nonsec;
    cap_val[FLD_HI:P_FLD_LO]   = page_m;
  end
endmodule

// File: rtl/s2far_rsp_stage.sv
module s2far_rsp_stage
  import s2far_pkg::*;
#(
  parameter int              P_REG_W = REG_W,
  parameter int              P_EC_W  = EC_W,
  parameter logic [P_EC_W-1:0] P_EC  = TRAP_EC_HYP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  acc_dec_t           dec,
  input  logic [P_REG_W-1:0] fa_q,
  output logic               rd_vld,
  output logic [P_REG_W-1:0] rd_data,
  output logic               acc_undef,
  output logic               acc_trap,
  output logic [P_EC_W-1:0]  trap_ec
);
  logic               vld_q, und_q, trp_q;
  logic               vld_d, und_d, trp_d;
  logic [P_REG_W-1:0] dat_q, dat_d;
  logic               rsp_en;

  always_comb begin
    vld_d  = dec.grant_rd;
    und_d  = dec.undef;
    trp_d  = dec.trap;
    dat_d  = dec.grant_rd ? fa_q : '0;
    rsp_en = dec.grant_rd | dec.undef | dec.trap | vld_q | und_q | trp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      und_q <= 1'b0;
      trp_q <= 1'b0;
      dat_q <= '0;
    end else if (rsp_en) begin
      vld_q <= vld_d;
      und_q <= und_d;
      trp_q <= trp_d;
      dat_q <= dat_d;
    end
  end

  assign rd_vld    = vld_q;
  assign rd_data   = dat_q;
  assign acc_undef = und_q;
  assign acc_trap  = trp_q;
  assign trap_ec   = trp_q ? P_EC : '0;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_vld, acc_undef, acc_trap})); // R9
  AST_RD_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_vld |-> (rd_data == '0)); // R9
endmodule

// File: rtl/s2_fault_addr_reg.sv
module s2_fault_addr_reg
  import s2far_pkg::*;
#(
  parameter int P_REG_W  = REG_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_PG_SH  = PG_SHIFT,
  parameter int P_FLD_LO = FLD_LO,
  parameter int P_NS_BIT = NS_BIT,
  parameter int P_EC_W   = EC_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cap_vld,
  input  logic [P_ADDR_W-P_PG_SH-1:0] cap_page,
  input  logic                        cap_nonsec,
  input  logic [1:0]                  cap_pa_sel,
  input  logic [1:0]                  cap_gran,
  input  logic                        cap_mem_op,
  input  logic                        lower_exec,
  input  logic                        acc_vld,
  input  logic [1:0]                  acc_op0,
  input  logic [2:0]                  acc_op1,
  input  logic [3:0]                  acc_crn,
  input  logic [3:0]                  acc_crm,
  input  logic [2:0]                  acc_op2,
  input  logic                        acc_wr,
  input  logic [1:0]                  acc_el,
  input  logic                        acc_nv_trap,
  input  logic [P_REG_W-1:0]          acc_wdata,
  output logic                        rd_vld,
  output logic [P_REG_W-1:0]          rd_data,
  output logic                        acc_undef,
  output logic                        acc_trap,
  output logic [P_EC_W-1:0]           trap_ec
);
  localparam int PG_W   = P_ADDR_W - P_PG_SH;
  localparam int FLD_HI = P_FLD_LO + PG_W - 1;

  acc_dec_t           dec;
  logic [P_REG_W-1:0] cap_val;
  logic [P_REG_W-1:0] wr_mask;
  logic [P_REG_W-1:0] fa_q, fa_d;
  logic               fa_en;

  for (genvar i = 0; i < P_REG_W; i++) begin : g_mask
    assign wr_mask[i] = (i == P_NS_BIT) || ((i >= P_FLD_LO) && (i <= FLD_HI));
  end

  s2far_access_dec u_dec (
    .acc_vld     (acc_vld),
    .acc_op0     (acc_op0),
    .acc_op1     (acc_op1),
    .acc_crn     (acc_crn),
    .acc_crm     (acc_crm),
    .acc_op2     (acc_op2),
    .acc_wr      (acc_wr),
    .acc_el      (acc_el),
    .acc_nv_trap (acc_nv_trap),
    .dec         (dec)
  );

  s2far_capture_fmt #(
    .P_REG_W  (P_REG_W),
    .P_ADDR_W (P_ADDR_W),
    .P_PG_SH  (P_PG_SH),
    .P_FLD_LO (P_FLD_LO),
    .P_NS_BIT (P_NS_BIT)
  ) u_fmt (
    .cap_page   (cap_page),
    .cap_nonsec (cap_nonsec),
    .cap_pa_sel (cap_pa_sel),
    .cap_gran   (cap_gran),
    .cap_mem_op (cap_mem_op),
    .cap_val    (cap_val)
  );

  // Next state: capture, then lower-level clear, then permitted write.
  always_comb begin
    fa_d  = fa_q;
    fa_en = 1'b0;
    if (cap_vld) begin
      fa_d  = cap_val;
      fa_en = 1'b1;
    end else if (lower_exec) begin
      fa_d  = '0;
      fa_en = 1'b1;
    end else if (dec.grant_wr) begin
      fa_d  = acc_wdata & wr_mask;
      fa_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fa_q <= '0;
    else if (fa_en) fa_q <= fa_d;
  end

  s2far_rsp_stage #(
    .P_REG_W (P_REG_W),
    .P_EC_W  (P_EC_W)
  ) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec       (dec),
    .fa_q      (fa_q),
    .rd_vld    (rd_vld),
    .rd_data   (rd_data),
    .acc_undef (acc_undef),
    .acc_trap  (acc_trap),
    .trap_ec   (trap_ec)
  );

  // Port-level view of the encoding, used by the checks below.
  logic enc_chk;
  assign enc_chk = (acc_op0 == 2'b11) && (acc_op1 == 3'b100) && (acc_crn == 4'b0110) &&
                   (acc_crm == 4'b0000) && (acc_op2 == 3'b100);

  AST_NOHIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && !enc_chk) |=> (!rd_vld && !acc_undef && !acc_trap)); // R5
  AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && enc_chk && acc_el == 2'd0) |=> (acc_undef && !rd_vld)); // R6
  AST_EL1_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && enc_chk && acc_el == 2'd1 && acc_nv_trap) |=> (acc_trap && trap_ec == 6'h18)); // R7
  AST_DENIED_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && enc_chk && acc_wr && acc_el < 2'd2 && !cap_vld && !lower_exec) |=> $stable(fa_q)); // R6
  AST_CAP_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld |=> (fa_q[P_NS_BIT] == $past(cap_nonsec))); // R2
  AST_CLEAR_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (lower_exec && !cap_vld) |=> (fa_q == '0)); // R11
  AST_RD_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> ((rd_data & ~wr_mask) == '0)); // R8
endmodule

// File: tb/tb_s2_fault_addr_reg.sv
module tb_s2_fault_addr_reg;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cap_vld, cap_nonsec, cap_mem_op, lower_exec;
  logic [43:0] cap_page;
  logic [1:0]  cap_pa_sel, cap_gran;
  logic        acc_vld, acc_wr, acc_nv_trap;
  logic [1:0]  acc_op0, acc_el;
  logic [2:0]  acc_op1, acc_op2;
  logic [3:0]  acc_crn, acc_crm;
  logic [63:0] acc_wdata;
  logic        rd_vld, acc_undef, acc_trap;
  logic [63:0] rd_data;
  logic [5:0]  trap_ec;

  localparam logic [63:0] MASK = 64'h8000_FFFF_FFFF_FFF0;

  always #4 clk = ~clk;

  s2_fault_addr_reg dut (.*);

  typedef struct {
    int          cyc;
    bit          v, u, t;
    logic [63:0] d;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          n_chk = 0, n_fail = 0;
  logic [63:0] m_reg = 64'h0;
  bit          done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] fmt(logic [55:0] a, bit ns, int pa, int gr, bit mop);
    int w, sh;
    logic [63:0] r;
    w  = (pa == 0) ? 48 : ((pa == 1) ? 52 : 56);
    sh = (gr == 1) ? 14 : ((gr == 2) ? 16 : 12);
    for (int i = 0; i < 56; i++)
      if (i >= w || (mop && i >= 12 && i < sh)) a[i] = 1'b0;
    r = 64'h0;
    r[63] = ns;
    r[47:4] = a[55:12];
    return r;
  endfunction

  task automatic idle();
    cap_vld = 0; cap_nonsec = 0; cap_mem_op = 0; lower_exec = 0;
    cap_page = '0; cap_pa_sel = 0; cap_gran = 0;
    acc_vld = 0; acc_wr = 0; acc_nv_trap = 0; acc_el = 0; acc_wdata = '0;
    acc_op0 = 2'b11; acc_op1 = 3'b100; acc_crn = 4'b0110; acc_crm = 4'b0000; acc_op2 = 3'b100;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  // Drives one access; bad: 0 = correct encoding, 1 = CRm, 2 = op2, 3 = op0 altered.
  // held: a capture or clear in the same cycle owns the register.
  task automatic set_acc(bit wr, int el, bit nv, logic [63:0] wd, int bad, bit held, string tag);
    exp_t e;
    acc_vld = 1; acc_wr = wr; acc_el = 2'(el); acc_nv_trap = nv; acc_wdata = wd;
    if (bad == 1) acc_crm = 4'b0001;
    if (bad == 2) acc_op2 = 3'b101;
    if (bad == 3) acc_op0 = 2'b10;
    e.cyc = cyc; e.v = 0; e.u = 0; e.t = 0; e.d = '0; e.tag = tag;
    if (bad == 0) begin
      if (el == 0) e.u = 1;
      else if (el == 1) begin
        if (nv) e.t = 1; else e.u = 1;
      end else if (!wr) begin
        e.v = 1; e.d = m_reg;
      end else if (!held) m_reg = wd & MASK;
    end
    sb.push_back(e);
  endtask

  task automatic acc(bit wr, int el, bit nv, logic [63:0] wd, int bad, string tag);
    set_acc(wr, el, nv, wd, bad, 0, tag);
    tick();
  endtask

  task automatic set_cap(logic [55:0] a, bit ns, int pa, int gr, bit mop);
    cap_vld = 1; cap_page = a[55:12]; cap_nonsec = ns;
    cap_pa_sel = 2'(pa); cap_gran = 2'(gr); cap_mem_op = mop;
    m_reg = fmt(a, ns, pa, gr, mop);
  endtask

  task automatic cap(logic [55:0] a, bit ns, int pa, int gr, bit mop);
    set_cap(a, ns, pa, gr, mop);
    tick();
  endtask

  task automatic rd(string tag);
    acc(0, 2, 0, '0, 0, tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // Monitor: scoreboard pop and compare, one response slot per cycle.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n === 1'b1) begin
        exp_t e;
        bit   have;
        have = (sb.size() > 0) && (sb[0].cyc == cyc - 1);
        if (have) e = sb.pop_front();
        else begin
          e.v = 0; e.u = 0; e.t = 0; e.d = '0; e.tag = "R9 idle cycle";
        end
        n_chk++;
        if (rd_vld !== e.v || acc_undef !== e.u || acc_trap !== e.t ||
            rd_data !== (e.v ? e.d : 64'h0) || trap_ec !== (e.t ? 6'h18 : 6'h0)) begin
          n_fail++;
          $display("FAIL %s: got v=%0b u=%0b t=%0b ec=%h d=%h exp v=%0b u=%0b t=%0b ec=%h d=%h",
                   e.tag, rd_vld, acc_undef, acc_trap, trap_ec, rd_data,
                   e.v, e.u, e.t, (e.t ? 6'h18 : 6'h0), (e.v ? e.d : 64'h0));
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (rd_vld !== 0 || acc_undef !== 0 || acc_trap !== 0 || rd_data !== 0) begin
      n_fail++;
      $display("FAIL R1 outputs in reset: got v=%0b u=%0b t=%0b d=%h exp 0 0 0 0",
               rd_vld, acc_undef, acc_trap, rd_data);
    end
    rst_n = 1;
    @(negedge clk);
    rd("R1 reset value");

    cap(56'h12_3456_789A_BCDE, 1, 2, 0, 0);  rd("R2 nonsecure capture");
    cap(56'hA5_5A5A_F00F_1234, 0, 3, 0, 0);  rd("R2 secure capture");

    cap({56{1'b1}}, 1, 0, 0, 0);             rd("R3 pa 48");
    cap({56{1'b1}}, 0, 1, 0, 0);             rd("R3 pa 52");
    cap({56{1'b1}}, 1, 3, 0, 0);             rd("R3 pa 56 alt code");

    cap({56{1'b1}}, 1, 2, 1, 1);             rd("R4 memop 16K");
    cap({56{1'b1}}, 0, 2, 2, 1);             rd("R4 memop 64K");
    cap({56{1'b1}}, 1, 2, 0, 1);             rd("R4 memop 4K");
    cap({56{1'b1}}, 1, 2, 3, 1);             rd("R4 memop reserved granule");
    cap({56{1'b1}}, 1, 2, 2, 0);             rd("R4 no memop keeps low bits");

    acc(0, 2, 0, '0, 1, "R5 bad CRm read");
    acc(1, 2, 0, {64{1'b1}}, 2, "R5 bad op2 write");
    acc(1, 3, 0, 64'h0, 3, "R5 bad op0 write");
    rd("R5 unchanged after bad encodings");

    acc(0, 0, 0, '0, 0, "R6 EL0 read undef");
    acc(1, 0, 1, 64'h0, 0, "R6 EL0 write undef");
    rd("R6 unchanged after EL0 write");

    acc(0, 1, 1, '0, 0, "R7 EL1 read trap");
    acc(0, 1, 0, '0, 0, "R7 EL1 read undef");
    acc(1, 1, 1, 64'h0, 0, "R7 EL1 write trap");
    acc(1, 1, 0, 64'h0, 0, "R7 EL1 write undef");
    rd("R7 unchanged after EL1 writes");

    acc(1, 2, 0, {64{1'b1}}, 0, "R8 EL2 write ones");
    acc(0, 3, 0, '0, 0, "R8 EL3 read masked");
    acc(1, 3, 0, 64'h0123_4567_89AB_CDEF, 0, "R8 EL3 write pattern");
    rd("R8 EL2 read pattern");
    rd("R9 back-to-back read");
    repeat (2) tick();

    set_cap(56'h00_1111_2222_3000, 1, 2, 0, 0);
    set_acc(1, 2, 0, {64{1'b1}}, 0, 1, "R10 write alongside capture");
    tick();
    rd("R10 capture wins");

    lower_exec = 1; m_reg = 64'h0; tick();
    rd("R11 cleared by lower exec");
    acc(1, 2, 0, 64'hFFFF_0000_FFFF_0000, 0, "R11 refill");
    lower_exec = 1;
    set_acc(1, 3, 0, {64{1'b1}}, 0, 1, "R11 write alongside clear");
    m_reg = 64'h0;
    tick();
    rd("R11 clear wins over write");
    lower_exec = 1;
    cap(56'h77_6655_4433_2000, 0, 1, 1, 0);
    rd("R11 capture wins over clear");

    repeat (4) tick();
    done = 1;
    summary();
    $finish;
  end
endmodule